// File: doc/BRIEF.md
# I2C Configuration Register Slave

This block is a two-wire serial slave that sits in front of a byte-wide configuration register file. Clock and data lines are brought in through synchronizer flops and a glitch filter. The block recognizes start, repeated start and stop conditions, compares a 7-bit device address, and takes part in two kinds of frame. The frames are described below. The register file stays outside the block. The block drives it through a one-cycle write strobe with address and data, and reads it through a combinational read-data input. The data line is driven only as an open-drain pull-down enable.

A write frame carries three parts after the address: a command byte whose two low bits must be zero, a register address byte, and any number of data bytes. Each data byte is written at the current pointer, and the pointer then steps forward by one. A write frame that stops after the register address only loads the pointer. A read frame always returns a fixed identification byte first. After that it returns register contents from the pointer, one byte at a time, stepping the pointer after each byte. The pointer is kept across frames and wraps from 0xFF to 0x00. The master ends a read by answering the last byte with a NACK.

Top module: `i2c_cfg_slave`

## Requirements
- R1: After reset the slave releases the data line (sda_oe_o=0), issues no write strobe, and reg_addr_o (the register pointer) is 0x00.
- R2: When the address byte does not match DEV_ADDR, the slave gives no ACK, never drives the data line and writes no register until the next start or stop.
- R3: A write frame consists of address with R/W bit 0, a command byte with bits [1:0]=00 (bits [7:2] ignored), a register address byte, and data bytes. Every byte is ACKed (data line low in the ninth clock). Each data byte is written at the pointer with a single one-cycle strobe, and the pointer then increments.
- R4: A command byte with bits [1:0] not 00 is NACKed. The rest of that frame gets no ACK, writes no register and leaves the pointer unchanged.
- R5: A read frame (address with R/W bit 1) is ACKed. The slave then sends ID_BYTE (0x10), MSB first, followed by the register at the pointer for each further byte. The pointer increments after each register byte is loaded for sending.
- R6: A write frame that carries only the command and register address loads the pointer, whether it ends with a stop or a repeated start. The pointer is held across a stop, so a following read continues at the next address.
- R7: The pointer wraps from 0xFF to 0x00 on both writes and reads.
- R8: After the master answers a byte with NACK, the slave releases the data line and sends nothing more in that frame.
- R9: A repeated start ends the current frame without a stop and starts a new address phase.
- R10: A clock-line pulse shorter than FILT_LEN clock cycles is not counted as a bit.
- R11: The slave changes its data-line drive only while the filtered clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen on the bus, asynchronous |
| sda_oe_o | output | 1 | Data line pull-down enable (1 drives low) |
| reg_we_o | output | 1 | Register file write strobe, one cycle |
| reg_addr_o | output | 8 | Register file address (the pointer) |
| reg_wdata_o | output | 8 | Register file write data |
| reg_rdata_i | input | 8 | Register file read data at reg_addr_o |

## Verification
The bench builds the block with its default parameters: DEV_ADDR 0x3A, ID_BYTE 0x10, two synchronizer stages and a three-cycle filter. The serial clock half-period is 24 system clocks, long enough that the synchronizer and filter latency stays well inside each bus phase. The three-cycle filter makes a single-cycle clock-line pulse a real test of rejection. An eight-bit pointer makes the 0xFF-to-0x00 wrap reachable with a few bytes on both write and read paths.

// File: rtl/i2c_cfg_pkg.sv
`timescale 1ns/1ps
package i2c_cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_REG,
    ST_WDATA,
    ST_RDATA,
    ST_IGNORE
  } slv_state_e;
endpackage

// File: rtl/i2c_sync_filt.sv
`timescale 1ns/1ps
module i2c_sync_filt #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   filt_q;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], in_i};
  end

  // output follows only after FILT_LEN consecutive differing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      filt_q <= 1'b1;
    end else if (synced == filt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(FILT_LEN - 1)) begin
      filt_q <= synced;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign filt_o = filt_q;
endmodule

// File: rtl/i2c_cond_det.sv
`timescale 1ns/1ps
module i2c_cond_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_f_i,
  input  logic sda_f_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f_i;
      sda_q <= sda_f_i;
    end
  end

  assign scl_rise_o = scl_f_i & ~scl_q;
  assign scl_fall_o = ~scl_f_i & scl_q;
  assign start_o    = scl_f_i & scl_q & sda_q & ~sda_f_i;
  assign stop_o     = scl_f_i & scl_q & ~sda_q & sda_f_i;
endmodule

// File: rtl/i2c_frame_fsm.sv
`timescale 1ns/1ps
module i2c_frame_fsm
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h3A,
  parameter logic [7:0] ID_BYTE  = 8'h10,
  parameter int         DW       = 8,
  parameter int         AW       = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          sda_f_i,
  output logic          sda_oe_o,
  output logic          reg_we_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  input  logic [DW-1:0] reg_rdata_i,
  output slv_state_e    state_o
);
  localparam int BCW = $clog2(DW + 1);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(DW);

  slv_state_e     state_q;
  logic           ack_q;      // in ninth-clock slot
  logic [BCW-1:0] bit_cnt_q;
  logic [DW-1:0]  rx_q, tx_q;
  logic [AW-1:0]  ptr_q;
  logic           oe_q, rw_q, mnack_q;
  logic           byte_done;

  assign byte_done = scl_fall_i && !ack_q && (bit_cnt_q == LAST_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ack_q     <= 1'b0;
      bit_cnt_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      oe_q      <= 1'b0;
      rw_q      <= 1'b0;
      mnack_q   <= 1'b0;
    end else if (start_i) begin
      state_q   <= ST_ADDR;
      ack_q     <= 1'b0;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else if (stop_i) begin
      state_q   <= ST_IDLE;
      ack_q     <= 1'b0;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_CMD, ST_REG, ST_WDATA: begin
          if (scl_rise_i && !ack_q) begin
            rx_q      <= {rx_q[DW-2:0], sda_f_i};
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
          if (scl_fall_i && ack_q) begin
            ack_q     <= 1'b0;
            oe_q      <= 1'b0;
            bit_cnt_q <= '0;
            case (state_q)
              ST_ADDR: begin
                if (rw_q) begin
                  state_q <= ST_RDATA;
                  tx_q    <= ID_BYTE;
                  oe_q    <= ~ID_BYTE[DW-1];
                end else begin
                  state_q <= ST_CMD;
                end
              end
              ST_CMD:  state_q <= ST_REG;
              ST_REG:  state_q <= ST_WDATA;
              default: state_q <= ST_WDATA;
            endcase
          end else if (byte_done) begin
            case (state_q)
              ST_ADDR: begin
                if (rx_q[7:1] == DEV_ADDR) begin
                  ack_q <= 1'b1;
                  oe_q  <= 1'b1;
                  rw_q  <= rx_q[0];
                end else begin
                  state_q <= ST_IGNORE;
                end
              end
              ST_CMD: begin
                if (rx_q[1:0] == 2'b00) begin
                  ack_q <= 1'b1;
                  oe_q  <= 1'b1;
                end else begin
                  state_q <= ST_IGNORE;
                end
              end
              ST_REG: begin
                ack_q <= 1'b1;
                oe_q  <= 1'b1;
                ptr_q <= rx_q[AW-1:0];
              end
              default: begin
                ack_q <= 1'b1;
                oe_q  <= 1'b1;
                ptr_q <= ptr_q + 1'b1;
              end
            endcase
          end
        end
        ST_RDATA: begin
          if (scl_rise_i) begin
            if (ack_q) mnack_q   <= sda_f_i;
            else       bit_cnt_q <= bit_cnt_q + 1'b1;
          end
          if (scl_fall_i) begin
            if (ack_q) begin
              if (mnack_q) begin
                state_q <= ST_IGNORE;
                oe_q    <= 1'b0;
              end else begin
                tx_q      <= reg_rdata_i;
                oe_q      <= ~reg_rdata_i[DW-1];
                ptr_q     <= ptr_q + 1'b1;
                ack_q     <= 1'b0;
                bit_cnt_q <= '0;
              end
            end else if (bit_cnt_q == LAST_BIT) begin
              ack_q <= 1'b1;
              oe_q  <= 1'b0;
            end else begin
              tx_q <= {tx_q[DW-2:0], 1'b0};
              oe_q <= ~tx_q[DW-2];
            end
          end
        end
        default: ;  // idle or ignoring: wait for start/stop
      endcase
    end
  end

  assign reg_we_o    = byte_done && (state_q == ST_WDATA);
  assign reg_addr_o  = ptr_q;
  assign reg_wdata_o = rx_q;
  assign sda_oe_o    = oe_q;
  assign state_o     = state_q;
endmodule

// File: rtl/i2c_cfg_slave.sv
`timescale 1ns/1ps
module i2c_cfg_slave
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h3A,
  parameter logic [7:0] ID_BYTE     = 8'h10,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic       reg_we_o,
  output logic [7:0] reg_addr_o,
  output logic [7:0] reg_wdata_o,
  input  logic [7:0] reg_rdata_i
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] line_raw, line_f;
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_c, stop_c;
  slv_state_e state;

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2c_sync_filt #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) i_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .in_i  (line_raw[g]),
      .filt_o(line_f[g])
    );
  end

  assign scl_f = line_f[0];
  assign sda_f = line_f[1];

  i2c_cond_det i_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_f_i   (scl_f),
    .sda_f_i   (sda_f),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_c),
    .stop_o    (stop_c)
  );

  i2c_frame_fsm #(
    .DEV_ADDR(DEV_ADDR),
    .ID_BYTE (ID_BYTE),
    .DW      (8),
    .AW      (8)
  ) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_c),
    .stop_i     (stop_c),
    .sda_f_i    (sda_f),
    .sda_oe_o   (sda_oe_o),
    .reg_we_o   (reg_we_o),
    .reg_addr_o (reg_addr_o),
    .reg_wdata_o(reg_wdata_o),
    .reg_rdata_i(reg_rdata_i),
    .state_o    (state)
  );
endmodule

// File: rtl/i2c_cfg_slave_chk.sv
`timescale 1ns/1ps
module i2c_cfg_slave_chk
  import i2c_cfg_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_f,
  input slv_state_e state,
  input logic       sda_oe_o,
  input logic       reg_we_o,
  input logic [7:0] reg_addr_o
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> (!sda_oe_o && !reg_we_o));

  // R2
  ignore_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IGNORE) |-> !sda_oe_o);

  // R3
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  // R4
  we_in_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (state == ST_WDATA));

  // R7
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> (reg_addr_o == 8'($past(reg_addr_o) + 8'd1)));

  // R11
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_f);
endmodule

bind i2c_cfg_slave i2c_cfg_slave_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_f     (scl_f),
  .state     (state),
  .sda_oe_o  (sda_oe_o),
  .reg_we_o  (reg_we_o),
  .reg_addr_o(reg_addr_o)
);

// File: tb/test_i2c_cfg_slave.sv
`timescale 1ns/1ps
module test_i2c_cfg_slave;
  localparam logic [6:0] ADDR = 7'h3A;
  localparam logic [7:0] ID   = 8'h10;
  localparam int H = 24;
  localparam int Q = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe_o, reg_we_o;
  logic [7:0] reg_addr_o, reg_wdata_o, reg_rdata_i;
  wire sda_line = sda_m & ~sda_oe_o;

  int n_chk = 0, n_err = 0, oe_mis = 0, wr_cnt = 0, exp_writes = 0;
  logic cmp_en = 1'b0, exp_drive = 1'b0, glitch_en = 1'b0, done = 1'b0;
  logic [7:0] rf [256];
  logic [7:0] exp_rf [256];
  logic [7:0] exp_ptr = 8'h00;

  always #2.5 clk = ~clk;

  i2c_cfg_slave i_i2c_cfg_slave (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sda_oe_o   (sda_oe_o),
    .reg_we_o   (reg_we_o),
    .reg_addr_o (reg_addr_o),
    .reg_wdata_o(reg_wdata_o),
    .reg_rdata_i(reg_rdata_i)
  );

  function automatic logic [7:0] init_val(int i);
    return 8'(i) ^ 8'h5A;
  endfunction

  // external register file
  assign reg_rdata_i = rf[reg_addr_o];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) rf[i] <= init_val(i);
    end else if (reg_we_o) begin
      rf[reg_addr_o] <= reg_wdata_o;
      wr_cnt <= wr_cnt + 1;
    end
  end

  // per-clock compare of drive against the model during SCL high
  always @(negedge clk) begin
    if (cmp_en && (sda_oe_o !== exp_drive)) oe_mis++;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, input logic drv, output logic s);
    if (glitch_en) begin
      wt(2); scl_m = 1'b1; wt(1); scl_m = 1'b0;
    end
    sda_m = b;
    wt(Q);
    scl_m = 1'b1;
    exp_drive = drv;
    wt(8);
    cmp_en = 1'b1;
    wt(H - 8);
    s = sda_line;
    cmp_en = 1'b0;
    scl_m = 1'b0;
    wt(Q);
  endtask

  task automatic start_c;
    sda_m = 1'b1; scl_m = 1'b1; wt(H);
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic rstart_c;
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic stop_c;
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
    logic s;
    for (int i = 7; i >= 0; i--) bit_x(b[i], 1'b0, s);
    bit_x(1'b1, exp_ack, s);
    chk(req, 32'(s), 32'(!exp_ack));
  endtask

  task automatic recv_byte(input logic [7:0] exp, input logic last, input string req);
    logic s;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      bit_x(1'b1, ~exp[i], s);
      got[i] = s;
    end
    bit_x(last, 1'b0, s);
    chk(req, 32'(got), 32'(exp));
  endtask

  task automatic wr_frame(input logic [7:0] cmd, input logic [7:0] ra,
                          input logic [7:0] d[$], input bit end_stop);
    bit ok;
    ok = (cmd[1:0] == 2'b00);
    start_c();
    send_byte({ADDR, 1'b0}, 1'b1, "R2 address ack");
    send_byte(cmd, ok, ok ? "R3 command ack" : "R4 command nack");
    if (ok) begin
      send_byte(ra, 1'b1, "R3 register address ack");
      exp_ptr = ra;
      foreach (d[k]) begin
        send_byte(d[k], 1'b1, "R3 data ack");
        exp_rf[exp_ptr] = d[k];
        exp_ptr = exp_ptr + 8'd1;
        exp_writes++;
      end
    end else begin
      send_byte(ra, 1'b0, "R4 ignored byte");
      foreach (d[k]) send_byte(d[k], 1'b0, "R4 ignored byte");
    end
    if (end_stop) stop_c();
  endtask

  task automatic rd_frame(input int n, input bit use_rstart, input string req);
    if (use_rstart) rstart_c();
    else            start_c();
    send_byte({ADDR, 1'b1}, 1'b1, req);
    recv_byte(ID, 1'b0, "R5 id byte");
    for (int k = 0; k < n; k++) begin
      recv_byte(exp_rf[exp_ptr], (k == n - 1), "R5 register byte");
      exp_ptr = exp_ptr + 8'd1;
    end
    wt(Q);
    chk("R8 released after nack", 32'(sda_oe_o), 32'd0);
    stop_c();
  endtask

  task automatic cmp_rf(input string req);
    int bad = 0;
    for (int i = 0; i < 256; i++) if (rf[i] !== exp_rf[i]) bad++;
    chk(req, 32'(bad), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) exp_rf[i] = init_val(i);
    wt(5);
    rst_n = 1'b1;
    wt(5);
    // R1
    chk("R1 oe after reset", 32'(sda_oe_o), 32'd0);
    chk("R1 we after reset", 32'(reg_we_o), 32'd0);
    chk("R1 pointer after reset", 32'(reg_addr_o), 32'd0);

    // R3: write three bytes, command upper bits set
    wr_frame(8'hFC, 8'h10, '{8'hA1, 8'hB2, 8'hC3}, 1'b1);
    cmp_rf("R3 register contents");

    // R6 + R9: pointer-only write then repeated start read
    wr_frame(8'h00, 8'h11, '{}, 1'b0);
    rd_frame(2, 1'b1, "R9 address ack after repeated start");
    chk("R6 pointer after read", 32'(reg_addr_o), 32'(exp_ptr));

    // R6: pointer held across stop
    rd_frame(1, 1'b0, "R6 read continues");

    // R2: foreign address, data must be ignored
    start_c();
    send_byte({ADDR ^ 7'h01, 1'b0}, 1'b0, "R2 no ack foreign address");
    send_byte(8'h00, 1'b0, "R2 ignored byte");
    send_byte(8'h20, 1'b0, "R2 ignored byte");
    send_byte(8'hEE, 1'b0, "R2 ignored byte");
    stop_c();
    cmp_rf("R2 no register change");

    // R4: bad command code
    wr_frame(8'h01, 8'h20, '{8'h77, 8'h88}, 1'b1);
    cmp_rf("R4 no register change");
    chk("R4 pointer unchanged", 32'(reg_addr_o), 32'(exp_ptr));
    rd_frame(1, 1'b0, "R4 read after bad command");

    // R7: wrap on write and on read
    wr_frame(8'h00, 8'hFE, '{8'h5A, 8'h6B, 8'h7C}, 1'b1);
    cmp_rf("R7 write wrap contents");
    chk("R7 pointer after write wrap", 32'(reg_addr_o), 32'h01);
    wr_frame(8'h00, 8'hFF, '{}, 1'b1);
    rd_frame(2, 1'b0, "R7 read wrap");
    chk("R7 pointer after read wrap", 32'(reg_addr_o), 32'h01);

    // R10: glitches on SCL while low
    glitch_en = 1'b1;
    wr_frame(8'h00, 8'h40, '{8'h3C, 8'hC3}, 1'b1);
    glitch_en = 1'b0;
    cmp_rf("R10 contents with glitches");
    wr_frame(8'h00, 8'h40, '{}, 1'b0);
    rd_frame(2, 1'b1, "R10 read back");

    chk("R3 write strobe count", 32'(wr_cnt), 32'(exp_writes));
    chk("R11 drive mismatches during SCL high", 32'(oe_mis), 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule